// File: doc/BRIEF.md
# Shifter Operand Generation Unit

This combinational unit builds the second ALU operand of a 32-bit data-processing instruction. It receives the 12-bit operand field, the immediate-select bit, the two register values that have already been read (the value to be shifted and the register that holds a shift amount) and the current carry flag. It returns the 32-bit operand, the carry the shifter produces, a code that names the operand submode in use, and a flag for words that belong to the extension space rather than to data processing.

There are eleven submodes. The first is an 8-bit constant rotated right by an even distance. The second passes a plain register through. Four shift types then take an amount from the field: logical left, logical right, arithmetic right and rotate right. The same four types also take an amount from a register. The last is a one-bit rotate through the carry. Each submode has its own rules for zero and out-of-range amounts. These rules set both the operand and the carry-out, and the unit applies them so that the flag logic downstream can use the carry directly.

Top module: `shifter_operand_unit`

## Requirements
- R1: `modeCode` encodes the submode. 0 is the rotated constant, 1 is the plain register, 2/3/4/5 are LSL/LSR/ASR/ROR by a field amount, 6 is rotate-with-extend, 7/8/9/10 are LSL/LSR/ASR/ROR by a register amount, and 15 is the extension space. The field amount is `opField[11:7]`. The shift type is `opField[6:5]` (00 LSL, 01 LSR, 10 ASR, 11 ROR). `opField[4]` selects a register amount.
- R2: With `immSel`=1, the operand is `opField[7:0]` rotated right by 2×`opField[11:8]`. The carry-out is `carryIn` when `opField[11:8]`=0 and is otherwise bit 31 of the operand.
- R3: A field-amount LSL by n shifts `op2Val` left by n. For n in 1..31 the carry is bit 32−n of `op2Val`. For n=0 (mode 1) the operand is `op2Val` and the carry is `carryIn`.
- R4: A field-amount LSR or ASR by n in 1..31 shifts right with zero or sign fill, and the carry is bit n−1 of `op2Val`. An amount of 0 acts as a shift by 32: LSR gives 0 and ASR gives 32 copies of bit 31. In both cases the carry is bit 31.
- R5: A field-amount ROR by n in 1..31 rotates right, and the carry is bit n−1 of `op2Val`. An amount of 0 selects rotate-with-extend: the operand is {`carryIn`, `op2Val[31:1]`} and the carry is `op2Val[0]`.
- R6: A register amount uses only `op3Val[7:0]`. When that byte is 0, the operand is `op2Val` and the carry is `carryIn`, whatever the shift type.
- R7: A register-amount LSL or LSR by 1..31 behaves like its field-amount counterpart. By exactly 32 it gives 0 with carry `op2Val[0]` (LSL) or `op2Val[31]` (LSR). By more than 32 it gives 0 with carry 0.
- R8: A register-amount ASR by 32 or more gives 32 copies of `op2Val[31]`, with that bit as the carry.
- R9: A register-amount ROR rotates by `op3Val[4:0]`, with carry bit (amount−1). A nonzero byte whose low 5 bits are 0 gives `op2Val` with carry `op2Val[31]`.
- R10: `immSel`=0 with `opField[4]`=1 and `opField[7]`=1 raises `extSpace`. The operand is then 0 and the carry is `carryIn`. `extSpace` is 0 for every other word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opField | input | 12 | Operand field of the instruction word |
| immSel | input | 1 | Immediate-select bit of the instruction word |
| op2Val | input | 32 | Value of the register to be shifted |
| op3Val | input | 32 | Value of the register holding a shift amount |
| carryIn | input | 1 | Current carry flag |
| shOperand | output | 32 | Generated operand |
| shCarry | output | 1 | Shifter carry-out |
| extSpace | output | 1 | Word lies in the extension space |
| modeCode | output | 4 | Submode code as listed in R1 |

## Verification
The hardest cases to reach are the register-amount edges. These are amounts of exactly 32, amounts above 32, multiples of 32 under ROR, and a low byte of zero while the upper bytes of `op3Val` are nonzero. Uniform random 32-bit amounts almost never land on them. The bench therefore drives directed vectors at each of these amounts, and its random phase draws the amount byte from a small set biased toward 0, 31, 32, 33 and 64. The field-amount zero cases and the extension-space pattern are also driven directly, under both carry values.

// File: rtl/shifter_operand_pkg.sv
`timescale 1ns/1ps
package shifter_operand_pkg;
  localparam int OP_W    = 32;
  localparam int FIELD_W = 12;
  localparam int IMM_W   = 8;
  localparam int ROT_W   = 4;
  localparam int SHAMT_W = $clog2(OP_W);
  localparam int AMT_W   = SHAMT_W + 1;
  localparam int RAMT_W  = 8;

  typedef enum logic [2:0] {
    SK_LSL, SK_LSR, SK_ASR, SK_ROR, SK_RRX
  } shKind_e;

  typedef enum logic [3:0] {
    M_IMM   = 4'd0,  M_REG   = 4'd1,
    M_LSL_I = 4'd2,  M_LSR_I = 4'd3, M_ASR_I = 4'd4, M_ROR_I = 4'd5,
    M_RRX   = 4'd6,
    M_LSL_R = 4'd7,  M_LSR_R = 4'd8, M_ASR_R = 4'd9, M_ROR_R = 4'd10,
    M_EXT   = 4'd15
  } mode_e;

  typedef struct packed {
    logic             srcImm;
    logic             squash;
    logic             keepCarry;
    logic             over;
    shKind_e          kind;
    logic [AMT_W-1:0] amt;
  } shCtrl_t;
endpackage

// File: rtl/shifter_operand_decode.sv
`timescale 1ns/1ps
module shifter_operand_decode
  import shifter_operand_pkg::*;
(
  input  logic [7:0]        fieldHi,
  input  logic              immSel,
  input  logic [RAMT_W-1:0] regAmt,
  output shCtrl_t           ctrl,
  output mode_e             mode,
  output logic              extSpace
);
  localparam logic [AMT_W-1:0]  FullAmt = AMT_W'(OP_W);
  localparam logic [RAMT_W-1:0] FullReg = RAMT_W'(OP_W);

  logic [SHAMT_W-1:0] fieldAmt;
  logic [ROT_W-1:0]   rotField;
  logic [1:0]         shType;
  logic               regSel;
  logic               bit7;
  logic               regBig;
  logic [AMT_W-1:0]   regClamp;
  logic [SHAMT_W-1:0] regLow;

  assign fieldAmt = fieldHi[7:3];
  assign rotField = fieldHi[7:4];
  assign bit7     = fieldHi[3];
  assign shType   = fieldHi[2:1];
  assign regSel   = fieldHi[0];
  assign regBig   = regAmt > FullReg;
  assign regClamp = (regAmt >= FullReg) ? FullAmt : AMT_W'(regAmt);
  assign regLow   = regAmt[SHAMT_W-1:0];

  always_comb begin
    ctrl     = '{srcImm: 1'b0, squash: 1'b0, keepCarry: 1'b0, over: 1'b0,
                 kind: SK_LSL, amt: '0};
    mode     = M_REG;
    extSpace = 1'b0;
    if (immSel) begin
      ctrl.srcImm    = 1'b1;
      ctrl.kind      = SK_ROR;
      ctrl.amt       = AMT_W'({rotField, 1'b0});
      ctrl.keepCarry = (rotField == '0);
      mode           = M_IMM;
    end else if (regSel && bit7) begin
      ctrl.squash = 1'b1;
      extSpace    = 1'b1;
      mode        = M_EXT;
    end else if (!regSel) begin
      unique case (shType)
        2'b00: begin
          ctrl.kind      = SK_LSL;
          ctrl.amt       = AMT_W'(fieldAmt);
          ctrl.keepCarry = (fieldAmt == '0);
          mode           = (fieldAmt == '0) ? M_REG : M_LSL_I;
        end
        2'b01: begin
          ctrl.kind = SK_LSR;
          ctrl.amt  = (fieldAmt == '0) ? FullAmt : AMT_W'(fieldAmt);
          mode      = M_LSR_I;
        end
        2'b10: begin
          ctrl.kind = SK_ASR;
          ctrl.amt  = (fieldAmt == '0) ? FullAmt : AMT_W'(fieldAmt);
          mode      = M_ASR_I;
        end
        default: begin
          if (fieldAmt == '0) begin
            ctrl.kind = SK_RRX;
            mode      = M_RRX;
          end else begin
            ctrl.kind = SK_ROR;
            ctrl.amt  = AMT_W'(fieldAmt);
            mode      = M_ROR_I;
          end
        end
      endcase
    end else begin
      ctrl.keepCarry = (regAmt == '0);
      unique case (shType)
        2'b00: begin
          ctrl.kind = SK_LSL;
          ctrl.amt  = regClamp;
          ctrl.over = regBig;
          mode      = M_LSL_R;
        end
        2'b01: begin
          ctrl.kind = SK_LSR;
          ctrl.amt  = regClamp;
          ctrl.over = regBig;
          mode      = M_LSR_R;
        end
        2'b10: begin
          ctrl.kind = SK_ASR;
          ctrl.amt  = regClamp;
          mode      = M_ASR_R;
        end
        default: begin
          ctrl.kind = SK_ROR;
          ctrl.amt  = (regLow == '0) ? FullAmt : AMT_W'(regLow);
          mode      = M_ROR_R;
        end
      endcase
    end
  end

  // R10: the extension-space flag never coexists with the immediate source
  always_comb begin
    a_r10_ext_not_imm: assert (!(extSpace && ctrl.srcImm))
      else $error("extension space decoded with immediate source");
  end
endmodule

// File: rtl/shifter_operand_datapath.sv
`timescale 1ns/1ps
module shifter_operand_datapath
  import shifter_operand_pkg::*;
#(
  parameter int OpW = OP_W
) (
  input  shCtrl_t          ctrl,
  input  logic [OpW-1:0]   op2Val,
  input  logic [IMM_W-1:0] immByte,
  input  logic             carryIn,
  output logic [OpW-1:0]   result,
  output logic             carryOut
);
  localparam int ShW = $clog2(OpW);

  logic [OpW-1:0]          src;
  logic [ShW:0][OpW-1:0]   stage;
  logic [OpW-1:0]          lslVal;
  logic [OpW-1:0]          lsrVal;
  logic [OpW-1:0]          asrVal;
  logic [AMT_W-1:0]        downFull;
  logic [AMT_W-1:0]        upFull;
  logic [ShW-1:0]          idxDown;
  logic [ShW-1:0]          idxUp;

  assign src = ctrl.srcImm ? {{(OpW-IMM_W){1'b0}}, immByte} : op2Val;

  assign stage[0] = src;
  for (genvar i = 0; i < ShW; i++) begin : g_rot
    localparam int Step = 1 << i;
    assign stage[i+1] = ctrl.amt[i]
      ? {stage[i][Step-1:0], stage[i][OpW-1:Step]}
      : stage[i];
  end

  assign lslVal   = src << ctrl.amt;
  assign lsrVal   = src >> ctrl.amt;
  assign asrVal   = (ctrl.amt >= AMT_W'(OpW)) ? {OpW{src[OpW-1]}}
                                             : OpW'($signed(src) >>> ctrl.amt);
  assign downFull = ctrl.amt - AMT_W'(1);
  assign upFull   = AMT_W'(OpW) - ctrl.amt;
  assign idxDown  = downFull[ShW-1:0];
  assign idxUp    = upFull[ShW-1:0];

  always_comb begin
    result   = src;
    carryOut = carryIn;
    if (ctrl.squash) begin
      result   = '0;
      carryOut = carryIn;
    end else if (ctrl.keepCarry) begin
      result   = src;
      carryOut = carryIn;
    end else begin
      unique case (ctrl.kind)
        SK_LSL: begin
          result   = ctrl.over ? '0 : lslVal;
          carryOut = ctrl.over ? 1'b0 : src[idxUp];
        end
        SK_LSR: begin
          result   = ctrl.over ? '0 : lsrVal;
          carryOut = ctrl.over ? 1'b0 : src[idxDown];
        end
        SK_ASR: begin
          result   = asrVal;
          carryOut = src[idxDown];
        end
        SK_ROR: begin
          result   = stage[ShW];
          carryOut = src[idxDown];
        end
        default: begin
          result   = {carryIn, src[OpW-1:1]};
          carryOut = src[0];
        end
      endcase
    end
  end

  // R8 / R4: an arithmetic shift keeps the sign of its source
  always_comb begin
    if (!ctrl.squash && ctrl.kind == SK_ASR)
      a_r8_asr_sign: assert (result[OpW-1] == src[OpW-1])
        else $error("arithmetic shift lost the sign bit");
  end
endmodule

// File: rtl/shifter_operand_unit.sv
`timescale 1ns/1ps
module shifter_operand_unit
  import shifter_operand_pkg::*;
#(
  parameter int OpW = OP_W
) (
  input  logic [FIELD_W-1:0] opField,
  input  logic               immSel,
  input  logic [OpW-1:0]     op2Val,
  input  logic [OpW-1:0]     op3Val,
  input  logic               carryIn,
  output logic [OpW-1:0]     shOperand,
  output logic               shCarry,
  output logic               extSpace,
  output logic [3:0]         modeCode
);
  shCtrl_t ctrl;
  mode_e   mode;
  logic    unusedAmtHi;

  assign unusedAmtHi = ^op3Val[OpW-1:RAMT_W];

  shifter_operand_decode u_decode (
    .fieldHi  (opField[FIELD_W-1:4]),
    .immSel   (immSel),
    .regAmt   (op3Val[RAMT_W-1:0]),
    .ctrl     (ctrl),
    .mode     (mode),
    .extSpace (extSpace)
  );

  shifter_operand_datapath #(.OpW(OpW)) u_datapath (
    .ctrl     (ctrl),
    .op2Val   (op2Val),
    .immByte  (opField[IMM_W-1:0]),
    .carryIn  (carryIn),
    .result   (shOperand),
    .carryOut (shCarry)
  );

  assign modeCode = mode;

  always_comb begin
    if (extSpace)
      a_r10_ext_squash: assert (shOperand == '0 && shCarry == carryIn)
        else $error("extension space did not squash the operand");
    if (immSel && opField[11:8] != '0)
      a_r2_imm_carry: assert (shCarry == shOperand[OpW-1])
        else $error("rotated constant carry mismatch");
    if (!immSel && opField[11:4] == 8'h00)
      a_r3_lsl0_pass: assert (shOperand == op2Val && shCarry == carryIn)
        else $error("plain register operand altered");
    if (!immSel && opField[4] && !opField[7] && !opField[6] &&
        op3Val[RAMT_W-1:0] > RAMT_W'(OpW))
      a_r7_big_zero: assert (shOperand == '0 && !shCarry)
        else $error("oversized logical shift not cleared");
  end
endmodule

// File: tb/shifter_operand_unit_bench.sv
`timescale 1ns/1ps
module shifter_operand_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] opField = '0;
  logic        immSel = 1'b0;
  logic [31:0] op2Val = '0;
  logic [31:0] op3Val = '0;
  logic        carryIn = 1'b0;
  logic [31:0] shOperand;
  logic        shCarry;
  logic        extSpace;
  logic [3:0]  modeCode;

  int vectors = 0;
  int misses  = 0;

  always #2.5 clk = ~clk;

  shifter_operand_unit u_shifter_operand_unit (
    .opField(opField), .immSel(immSel), .op2Val(op2Val), .op3Val(op3Val),
    .carryIn(carryIn), .shOperand(shOperand), .shCarry(shCarry),
    .extSpace(extSpace), .modeCode(modeCode)
  );

  function automatic logic [32:0] shiftRef(int t, int amt, logic [31:0] v, logic c);
    longint x;
    int a;
    x = longint'(v);
    if (amt == 0) return {c, v};
    case (t)
      0: if (amt < 32) return {v[32-amt], v << amt};
         else if (amt == 32) return {v[0], 32'h0};
         else return 33'h0;
      1: if (amt < 32) return {v[amt-1], v >> amt};
         else if (amt == 32) return {v[31], 32'h0};
         else return 33'h0;
      2: if (amt >= 32) return {v[31], {32{v[31]}}};
         else return {v[amt-1], 32'($signed(v) >>> amt)};
      default: begin
        a = amt % 32;
        if (a == 0) return {v[31], v};
        return {v[a-1], 32'(((x >> a) | (x << (32 - a))) & 64'hFFFF_FFFF)};
      end
    endcase
  endfunction

  // returns {mode[3:0], ext, tagIdx[3:0], carry, operand[31:0]}
  function automatic logic [41:0] refModel(logic [11:0] f, logic im,
                                           logic [31:0] a, logic [31:0] b, logic c);
    logic [32:0] r;
    longint x;
    int rot, n, t;
    if (im) begin
      rot = 2 * int'(f[11:8]);
      x = longint'(f[7:0]);
      r[31:0] = 32'(((x >> rot) | (x << (32 - rot))) & 64'hFFFF_FFFF);
      r[32] = (rot == 0) ? c : r[31];
      return {4'd0, 1'b0, 4'd2, r};
    end
    if (f[4] && f[7]) return {4'd15, 1'b1, 4'd10, c, 32'h0};
    t = int'(f[6:5]);
    if (!f[4]) begin
      n = int'(f[11:7]);
      case (t)
        0: return {(n == 0) ? 4'd1 : 4'd2, 1'b0, 4'd3, shiftRef(0, n, a, c)};
        1: return {4'd3, 1'b0, 4'd4, shiftRef(1, (n == 0) ? 32 : n, a, c)};
        2: return {4'd4, 1'b0, 4'd4, shiftRef(2, (n == 0) ? 32 : n, a, c)};
        default:
          if (n == 0) return {4'd6, 1'b0, 4'd5, a[0], c, a[31:1]};
          else return {4'd5, 1'b0, 4'd5, shiftRef(3, n, a, c)};
      endcase
    end
    n = int'(b[7:0]);
    r = shiftRef(t, n, a, c);
    if (n == 0) return {4'(7 + t), 1'b0, 4'd6, r};
    case (t)
      0, 1: return {4'(7 + t), 1'b0, 4'd7, r};
      2: return {4'd9, 1'b0, 4'd8, r};
      default: return {4'd10, 1'b0, 4'd9, r};
    endcase
  endfunction

  task automatic apply(logic [11:0] f, logic im, logic [31:0] a, logic [31:0] b, logic c);
    logic [41:0] e;
    int tag;
    @(negedge clk);
    opField <= f; immSel <= im; op2Val <= a; op3Val <= b; carryIn <= c;
    @(posedge clk);
    #1;
    e = refModel(f, im, a, b, c);
    tag = int'(e[36:33]);
    vectors++;
    if (shOperand !== e[31:0]) begin
      misses++;
      $display("FAIL R%0d operand f=%h i=%b: actual %h expected %h", tag, f, im, shOperand, e[31:0]);
    end
    if (shCarry !== e[32]) begin
      misses++;
      $display("FAIL R%0d carry f=%h i=%b: actual %b expected %b", tag, f, im, shCarry, e[32]);
    end
    if (extSpace !== e[37]) begin
      misses++;
      $display("FAIL R10 extSpace f=%h i=%b: actual %b expected %b", f, im, extSpace, e[37]);
    end
    if (modeCode !== e[41:38]) begin
      misses++;
      $display("FAIL R1 modeCode f=%h i=%b: actual %0d expected %0d", f, im, modeCode, e[41:38]);
    end
  endtask

  function automatic logic [11:0] fImm(int rot, logic [7:0] k);
    return {4'(rot), k};
  endfunction
  function automatic logic [11:0] fFld(int n, int t);
    return {5'(n), 2'(t), 1'b0, 4'h2};
  endfunction
  function automatic logic [11:0] fReg(int t);
    return {4'h3, 1'b0, 2'(t), 1'b1, 4'h2};
  endfunction

  initial begin
    #(5.0 * 200000);
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    logic [7:0] edges [8];
    edges = '{8'd0, 8'd31, 8'd32, 8'd33, 8'd64, 8'd1, 8'd255, 8'd96};
    repeat (3) @(posedge clk);
    apply('0, 1'b0, '0, '0, 1'b0);             // reset state, R1 R3
    rst = 1'b0;
    // R2 rotated constant
    apply(fImm(0, 8'hFF), 1'b1, '0, '0, 1'b1);
    apply(fImm(1, 8'hFF), 1'b1, '0, '0, 1'b0);
    apply(fImm(4, 8'hFF), 1'b1, '0, '0, 1'b0);
    apply(fImm(14, 8'h14), 1'b1, '0, '0, 1'b1);
    // R3 field LSL
    apply(fFld(0, 0), 1'b0, 32'h8000_0001, '0, 1'b1);
    apply(fFld(3, 0), 1'b0, 32'hE000_0001, '0, 1'b0);
    apply(fFld(31, 0), 1'b0, 32'h0000_0003, '0, 1'b0);
    // R4 field LSR/ASR, zero means 32
    apply(fFld(0, 1), 1'b0, 32'h8000_0000, '0, 1'b0);
    apply(fFld(1, 1), 1'b0, 32'h0000_0003, '0, 1'b0);
    apply(fFld(0, 2), 1'b0, 32'h8000_1234, '0, 1'b0);
    apply(fFld(5, 2), 1'b0, 32'hF000_0010, '0, 1'b0);
    // R5 field ROR and rotate-with-extend
    apply(fFld(8, 3), 1'b0, 32'h1234_5680, '0, 1'b0);
    apply(fFld(0, 3), 1'b0, 32'h0000_0003, '0, 1'b1);
    apply(fFld(0, 3), 1'b0, 32'h0000_0002, '0, 1'b0);
    // R6 zero register amount, upper bytes ignored
    for (int t = 0; t < 4; t++) apply(fReg(t), 1'b0, 32'hA5A5_0F0F, 32'hFFFF_FF00, 1'b1);
    apply(fReg(0), 1'b0, 32'h0000_0011, 32'hABCD_EF04, 1'b0);
    // R7 R8 R9 register edges
    for (int t = 0; t < 4; t++)
      for (int k = 0; k < 8; k++) begin
        apply(fReg(t), 1'b0, 32'h8000_0001, {24'h0, edges[k]}, 1'b0);
        apply(fReg(t), 1'b0, 32'h7FFF_FFFE, {24'h0, edges[k]}, 1'b1);
      end
    // R10 extension space
    apply(12'h092, 1'b0, 32'hFFFF_FFFF, 32'h1, 1'b1);
    apply(12'hFF2, 1'b0, 32'h1234_5678, 32'h5, 1'b0);
    apply(12'h092, 1'b1, 32'hFFFF_FFFF, 32'h1, 1'b0);
    // random mix across all submodes
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] b;
      b = $urandom;
      if ($urandom_range(0, 1) == 0) b[7:0] = edges[$urandom_range(0, 7)];
      apply(12'($urandom), 1'($urandom), $urandom, b, 1'($urandom));
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule